// File: doc/BRIEF.md
# Firmware Download Framer with CRC-16 Trailer

This block turns a raw firmware image, arriving one byte at a time on a valid/ready stream, into the ordered sequence of register accesses that a slave device needs in order to load code into its internal RAM. Every output beat names a target register and a data byte. First and last markers group the beats into bus transactions, and a read flag marks the single read request in the sequence. A downstream serial-bus master is expected to consume the beats and turn each marked group into one bus transfer.

A start pulse loads the image length and the RAM base choice. The framer then produces the full sequence in a fixed order. It writes the control register to hold the target's microcontroller in reset. It sends a three-byte header with the RAM base and a mode byte. It passes the payload through in bursts of limited size while folding every accepted byte into a CRC-16. It appends the checksum and issues one read request as a fence. Finally it releases the control register and pulses done. If the byte stream ends before the programmed length, the framer raises an error flag and drops back to idle.

Top module: `fwdl_framer`

## Requirements
- R1: The first beat after an accepted start is a single-beat transaction (first and last both set) that writes 0x80 to register 0x2B.
- R2: Next comes a three-beat transaction to register 0x29 carrying RAM base high byte, RAM base low byte, then 0x81; the base is 0x1000 when `base_sel` is 0 and 0x0000 when it is 1, sampled with the start pulse.
- R3: Payload bytes go in arrival order to register 0x2C, grouped into transactions of at most 255 beats; `out_first` marks the first beat of each group and `out_last` marks beat 255 or the final payload byte, so the last group carries the remainder.
- R4: After the payload comes a two-beat transaction to 0x2C carrying a CRC-16 of the payload, high byte first. The CRC uses polynomial 0x1021 and initial value 0, MSB-first, and each byte is XORed into bits 15:8 before eight shift steps. The nine ASCII bytes "123456789" give 0x31C3.
- R5: After the CRC comes one single-beat read request (`out_rd`=1, register 0x2C, data 0x00), then a single-beat write of 0x80 to register 0x2B.
- R6: `done` is high for exactly one cycle, in the cycle after the final release beat is accepted, and `busy` is low from that cycle on.
- R7: Under any pattern of `out_ready` and `in_valid`, no beat is lost, duplicated or reordered. `in_ready` is high only in the payload phase and only while `out_ready` is high. A stalled output beat holds its register, data and markers.
- R8: If `in_last` accompanies a payload byte before the programmed length is reached, that beat is marked last, `err` goes high and stays high until the next accepted start, and the framer returns to idle with no CRC, read or release beats and no `done`.
- R9: A start pulse is ignored while `busy` is high, and ignored when the length is 0.
- R10: After reset, `busy`, `out_valid`, `in_ready`, `done` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a download (one-cycle pulse) |
| fw_len | input | 16 | Image length in bytes, 1 to 65535, sampled with start |
| base_sel | input | 1 | 0 selects RAM base 0x1000, 1 selects 0x0000 |
| in_valid | input | 1 | Firmware byte valid |
| in_data | input | 8 | Firmware byte |
| in_last | input | 1 | Marks the final byte the source will deliver |
| in_ready | output | 1 | Firmware byte accepted this cycle when valid |
| out_valid | output | 1 | Register beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_addr | output | 8 | Target register address |
| out_data | output | 8 | Byte to write (0 for a read request) |
| out_first | output | 1 | First beat of a transaction |
| out_last | output | 1 | Last beat of a transaction |
| out_rd | output | 1 | Beat is a read request |
| busy | output | 1 | A download is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Input stream ended early |

## Verification
Images of 1, 5, 255, 256 and 300 bytes are run. These separate a lone byte, a group that fills exactly to the cap, a cap followed by a one-byte remainder, and a cap followed by a longer remainder. The ASCII digit string is checked against a fixed CRC, so a wrong polynomial, seed or bit order cannot hide behind a bench model that shares the same mistake. The same images are repeated with a pseudo-random `out_ready` and idle gaps on `in_valid`, which shows that stalls on either side cost no beats. An early `in_last`, a start pulse during a run and a zero-length start show the abort path and the inputs that must be ignored.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;

    localparam logic [7:0] REG_CTRL   = 8'h2B;
    localparam logic [7:0] REG_ADDR   = 8'h29;
    localparam logic [7:0] REG_DATA   = 8'h2C;
    localparam logic [7:0] CTRL_HOLD  = 8'h80;
    localparam logic [7:0] CTRL_DONE  = 8'h80;
    localparam logic [7:0] HDR_MODE   = 8'h81;
    localparam logic [15:0] CRC_POLY  = 16'h1021;
    localparam logic [15:0] CRC_SEED  = 16'h0000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HOLD,
        ST_HDR_HI,
        ST_HDR_LO,
        ST_HDR_MODE,
        ST_PAY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_RDBK,
        ST_REL
    } fw_state_e;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       first;
        logic       last;
        logic       rd;
    } fw_beat_t;

    // One byte of MSB-first CRC-16: byte folded into the top octet, eight shifts.
    function automatic logic [15:0] crc_byte(input logic [15:0] cur, input logic [7:0] b);
        logic [15:0] r;
        r = cur ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) begin
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fwdl_crc16.sv
module fwdl_crc16
    import fwdl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= CRC_SEED;
        end else if (en) begin
            crc <= crc_byte(crc, din);
        end
    end

endmodule

// File: rtl/fwdl_count.sv
module fwdl_count #(
    parameter int LEN_W     = 16,
    parameter int MAX_BURST = 255
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             step,
    input  logic             close,
    output logic             rem_is_one,
    output logic             burst_full,
    output logic             burst_start
);

    localparam int BCNT_W = $clog2(MAX_BURST + 1);
    localparam logic [BCNT_W-1:0] BCNT_TOP = BCNT_W'(MAX_BURST - 1);

    logic [LEN_W-1:0]  rem;
    logic [BCNT_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= len;
        end else if (step) begin
            rem <= rem - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            bcnt <= '0;
        end else if (step) begin
            bcnt <= close ? '0 : bcnt + 1'b1;
        end
    end

    assign rem_is_one  = (rem == LEN_W'(1));
    assign burst_full  = (bcnt == BCNT_TOP);
    assign burst_start = (bcnt == '0);

endmodule

// File: rtl/fwdl_seq.sv
module fwdl_seq
    import fwdl_pkg::*;
#(
    parameter logic [15:0] BASE_DEFAULT = 16'h1000,
    parameter logic [15:0] BASE_ALT     = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_ok,
    input  logic        base_sel,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic        out_ready,
    input  logic        rem_is_one,
    input  logic        burst_full,
    input  logic        burst_start,
    input  logic [15:0] crc,
    output fw_beat_t    beat,
    output logic        out_valid,
    output logic        in_ready,
    output logic        pay_fire,
    output logic        burst_close,
    output logic        busy,
    output logic        done,
    output logic        err
);

    fw_state_e   state;
    logic [15:0] base;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            base  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state <= ST_HOLD;
                        base  <= base_sel ? BASE_ALT : BASE_DEFAULT;
                        err   <= 1'b0;
                    end
                end
                ST_HOLD:     if (out_ready) state <= ST_HDR_HI;
                ST_HDR_HI:   if (out_ready) state <= ST_HDR_LO;
                ST_HDR_LO:   if (out_ready) state <= ST_HDR_MODE;
                ST_HDR_MODE: if (out_ready) state <= ST_PAY;
                ST_PAY: begin
                    if (pay_fire) begin
                        if (rem_is_one) begin
                            state <= ST_CRC_HI;
                        end else if (in_last) begin
                            err   <= 1'b1;
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_CRC_HI:   if (out_ready) state <= ST_CRC_LO;
                ST_CRC_LO:   if (out_ready) state <= ST_RDBK;
                ST_RDBK:     if (out_ready) state <= ST_REL;
                ST_REL: begin
                    if (out_ready) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default:     state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        beat      = '0;
        out_valid = 1'b1;
        in_ready  = 1'b0;
        unique case (state)
            ST_IDLE:     out_valid = 1'b0;
            ST_HOLD:     beat = '{addr: REG_CTRL, data: CTRL_HOLD,  first: 1'b1, last: 1'b1, rd: 1'b0};
            ST_HDR_HI:   beat = '{addr: REG_ADDR, data: base[15:8], first: 1'b1, last: 1'b0, rd: 1'b0};
            ST_HDR_LO:   beat = '{addr: REG_ADDR, data: base[7:0],  first: 1'b0, last: 1'b0, rd: 1'b0};
            ST_HDR_MODE: beat = '{addr: REG_ADDR, data: HDR_MODE,   first: 1'b0, last: 1'b1, rd: 1'b0};
            ST_PAY: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                beat = '{addr: REG_DATA, data: in_data, first: burst_start,
                         last: burst_full | rem_is_one | in_last, rd: 1'b0};
            end
            ST_CRC_HI:   beat = '{addr: REG_DATA, data: crc[15:8],  first: 1'b1, last: 1'b0, rd: 1'b0};
            ST_CRC_LO:   beat = '{addr: REG_DATA, data: crc[7:0],   first: 1'b0, last: 1'b1, rd: 1'b0};
            ST_RDBK:     beat = '{addr: REG_DATA, data: 8'h00,      first: 1'b1, last: 1'b1, rd: 1'b1};
            ST_REL:      beat = '{addr: REG_CTRL, data: CTRL_DONE,  first: 1'b1, last: 1'b1, rd: 1'b0};
            default:     out_valid = 1'b0;
        endcase
    end

    assign pay_fire    = (state == ST_PAY) && in_valid && out_ready;
    assign burst_close = pay_fire && beat.last;
    assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/fwdl_framer.sv
module fwdl_framer
    import fwdl_pkg::*;
#(
    parameter int          LEN_W        = 16,
    parameter int          MAX_BURST    = 255,
    parameter logic [15:0] BASE_DEFAULT = 16'h1000,
    parameter logic [15:0] BASE_ALT     = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] fw_len,
    input  logic             base_sel,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_addr,
    output logic [7:0]       out_data,
    output logic             out_first,
    output logic             out_last,
    output logic             out_rd,
    output logic             busy,
    output logic             done,
    output logic             err
);

    fw_beat_t    beat;
    logic        start_ok;
    logic        pay_fire;
    logic        burst_close;
    logic        rem_is_one;
    logic        burst_full;
    logic        burst_start;
    logic [15:0] crc;

    assign start_ok = start && !busy && (fw_len != '0);

    fwdl_count #(
        .LEN_W     (LEN_W),
        .MAX_BURST (MAX_BURST)
    ) u_count (
        .clk         (clk),
        .rst         (rst),
        .load        (start_ok),
        .len         (fw_len),
        .step        (pay_fire),
        .close       (burst_close),
        .rem_is_one  (rem_is_one),
        .burst_full  (burst_full),
        .burst_start (burst_start)
    );

    fwdl_crc16 u_crc (
        .clk (clk),
        .rst (rst),
        .clr (start_ok),
        .en  (pay_fire),
        .din (in_data),
        .crc (crc)
    );

    fwdl_seq #(
        .BASE_DEFAULT (BASE_DEFAULT),
        .BASE_ALT     (BASE_ALT)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_ok    (start_ok),
        .base_sel    (base_sel),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .out_ready   (out_ready),
        .rem_is_one  (rem_is_one),
        .burst_full  (burst_full),
        .burst_start (burst_start),
        .crc         (crc),
        .beat        (beat),
        .out_valid   (out_valid),
        .in_ready    (in_ready),
        .pay_fire    (pay_fire),
        .burst_close (burst_close),
        .busy        (busy),
        .done        (done),
        .err         (err)
    );

    assign out_addr  = beat.addr;
    assign out_data  = beat.data;
    assign out_first = beat.first;
    assign out_last  = beat.last;
    assign out_rd    = beat.rd;

endmodule

// File: rtl/fwdl_framer_chk.sv
module fwdl_framer_chk #(
    parameter int MAX_BURST = 255
) (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_addr,
    input logic [7:0] out_data,
    input logic       out_first,
    input logic       out_last,
    input logic       out_rd,
    input logic       done,
    input logic       err
);

    localparam int CW = $clog2(MAX_BURST + 2);

    logic [CW-1:0] run_len;
    logic          fire_wr_data;

    assign fire_wr_data = out_valid && out_ready && (out_addr == 8'h2C) && !out_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (fire_wr_data) begin
            run_len <= out_first ? CW'(1) : run_len + 1'b1;
        end
    end

    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (out_valid && out_addr == 8'h2B && out_data == 8'h80 && out_first && out_last)); // R1

    AST_BURST_CAP: assert property (@(posedge clk) disable iff (rst)
        run_len <= CW'(MAX_BURST)); // R3

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)
                                       && $stable(out_first) && $stable(out_last) && $stable(out_rd))); // R7

    AST_INREADY_GATED: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (out_ready && busy)); // R7

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(out_valid && out_ready && out_addr == 8'h2B && !out_rd) && !busy)); // R6

    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        err |-> !done); // R8

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy); // R8

    AST_NO_INPUT_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (out_valid && out_addr == 8'h2C)); // R3

endmodule

bind fwdl_framer fwdl_framer_chk #(.MAX_BURST(MAX_BURST)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last),
    .out_rd    (out_rd),
    .done      (done),
    .err       (err)
);

// File: tb/tb_fwdl_framer.sv
module tb_fwdl_framer;

    localparam int CLK_PERIOD = 10;
    localparam int CAP        = 255;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] fw_len = '0;
    logic        base_sel = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_addr, out_data;
    logic        out_first, out_last, out_rd;
    logic        busy, done, err;

    fwdl_framer dut (
        .clk (clk), .rst (rst), .start (start), .fw_len (fw_len), .base_sel (base_sel),
        .in_valid (in_valid), .in_data (in_data), .in_last (in_last), .in_ready (in_ready),
        .out_valid (out_valid), .out_ready (out_ready), .out_addr (out_addr), .out_data (out_data),
        .out_first (out_first), .out_last (out_last), .out_rd (out_rd),
        .busy (busy), .done (done), .err (err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] data;
        logic       first;
        logic       last;
        logic       rd;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [7:0] fw_bytes[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit bp_mode = 1'b0;
    bit gap_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    bit finished = 1'b0;

    // Bench model of the checksum, written from R4.
    function automatic logic [15:0] model_crc(input int n);
        logic [15:0] c = 16'h0000;
        for (int i = 0; i < n; i++) begin
            c = c ^ {fw_bytes[i], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] a, input logic [7:0] d, input logic f, input logic l,
                        input logic r, input string tag);
        exp_t e;
        e.addr = a; e.data = d; e.first = f; e.last = l; e.rd = r; e.tag = tag;
        sb.push_back(e);
    endtask

    // Downstream ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: pops the scoreboard on every accepted output beat.
    always @(negedge clk) begin
        if (!rst && done) done_cnt++;
        if (!rst && out_valid && out_ready) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL R7: unexpected beat actual=%h/%h expected=none", out_addr, out_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (out_addr !== e.addr || out_data !== e.data || out_first !== e.first ||
                    out_last !== e.last || out_rd !== e.rd) begin
                    errors++;
                    $display("FAIL %s: actual a=%h d=%h f=%b l=%b rd=%b expected a=%h d=%h f=%b l=%b rd=%b",
                             e.tag, out_addr, out_data, out_first, out_last, out_rd,
                             e.addr, e.data, e.first, e.last, e.rd);
                end
            end
        end
    end

    // Runs one download of fw_len=len; fw_bytes holds what the source delivers.
    // Fewer bytes than len means an early end (R8). glitch_at >= 0 pulses start mid-run (R9).
    task automatic run_fw(input int len, input bit sel, input int glitch_at, input bit use_fixed,
                          input logic [15:0] fixed_crc);
        int sent = fw_bytes.size();
        bit early = (sent < len);
        logic [15:0] base = sel ? 16'h0000 : 16'h1000;
        logic [15:0] c = use_fixed ? fixed_crc : model_crc(sent);
        int d0 = done_cnt;
        int wait_cyc = 0;

        push(8'h2B, 8'h80, 1, 1, 0, "R1");
        push(8'h29, base[15:8], 1, 0, 0, "R2");
        push(8'h29, base[7:0], 0, 0, 0, "R2");
        push(8'h29, 8'h81, 0, 1, 0, "R2");
        for (int i = 0; i < sent; i++)
            push(8'h2C, fw_bytes[i], (i % CAP) == 0,
                 ((i % CAP) == CAP - 1) || (i == len - 1) || (early && i == sent - 1), 0,
                 early ? "R8" : "R3");
        if (!early) begin
            push(8'h2C, c[15:8], 1, 0, 0, "R4");
            push(8'h2C, c[7:0], 0, 1, 0, "R4");
            push(8'h2C, 8'h00, 1, 1, 1, "R5");
            push(8'h2B, 8'h80, 1, 1, 0, "R5");
        end

        @(posedge clk); #1;
        start = 1'b1; fw_len = 16'(len); base_sel = sel;
        @(posedge clk); #1;
        start = 1'b0; base_sel = ~sel;

        for (int i = 0; i < sent; i++) begin
            if (gap_mode && (i % 7) == 3) begin
                in_valid = 1'b0;
                @(posedge clk); #1;
            end
            in_valid = 1'b1;
            in_data  = fw_bytes[i];
            in_last  = (i == sent - 1);
            if (i == glitch_at) begin
                start = 1'b1; fw_len = 16'd7;
            end
            do @(negedge clk); while (!in_ready);
            @(posedge clk); #1;
            start = 1'b0;
            in_valid = 1'b0; in_last = 1'b0;
        end

        while ((sb.size() != 0 || busy) && wait_cyc < 5000) begin
            @(posedge clk); #1;
            wait_cyc++;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sb.size() == 0, early ? "R8" : "R5", "beats left in scoreboard", sb.size(), 0);
        check(done_cnt - d0 == (early ? 0 : 1), early ? "R8" : "R6", "done pulses", done_cnt - d0,
              early ? 0 : 1);
        check(err == early, "R8", "err flag", err, early);
        check(!busy, "R6", "busy after run", busy, 0);
        sb.delete();
    endtask

    task automatic fill(input int n, input int seed);
        fw_bytes.delete();
        for (int i = 0; i < n; i++) fw_bytes.push_back(8'((i * 37 + seed * 11 + (i >> 3)) & 8'hFF));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!busy && !out_valid && !in_ready && !done && !err, "R10", "reset outputs",
              {busy, out_valid, in_ready, done, err}, 0);

        // R4: fixed vector "123456789"
        fw_bytes.delete();
        for (int i = 0; i < 9; i++) fw_bytes.push_back(8'h31 + 8'(i));
        run_fw(9, 0, -1, 1, 16'h31C3);

        fill(5, 1);   run_fw(5, 0, -1, 0, 0);     // R1 R2 R3 short image
        fill(1, 2);   run_fw(1, 1, -1, 0, 0);     // R3 single byte, alt base R2
        fill(255, 3); run_fw(255, 0, -1, 0, 0);   // R3 exactly one full group
        fill(256, 4); run_fw(256, 1, -1, 0, 0);   // R3 full group plus one

        bp_mode = 1'b1; gap_mode = 1'b1;
        fill(300, 5); run_fw(300, 1, -1, 0, 0);   // R7 stalls on both sides
        fill(20, 6);  run_fw(20, 0, 8, 0, 0);     // R9 start during run ignored
        fill(4, 7);   run_fw(10, 0, -1, 0, 0);    // R8 early end
        fill(6, 8);   run_fw(6, 0, -1, 0, 0);     // R8 err clears on next start
        bp_mode = 1'b0; gap_mode = 1'b0;

        // R9: zero length start is ignored
        @(posedge clk); #1;
        start = 1'b1; fw_len = 16'd0;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!busy && !out_valid, "R9", "zero-length start", {busy, out_valid}, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL R7: watchdog expired actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule